// File: doc/BRIEF.md
# Thread-Partitioned Write-Back Data Cache

This block is a data cache shared by many hardware threads of a fine-grained multithreaded pipeline. Every thread owns a private, fixed slice of the line storage, picked by its thread number, so threads never evict each other. Within its slice, a thread sees a direct-mapped, write-back, write-allocate cache with 32-byte lines and physical tags. The total line count is a parameter. The per-thread slice is that total divided by the thread count: with the default 512 lines, 64 threads get 8 lines (256 bytes) each and 32 threads get 16 lines (512 bytes) each.

The CPU side presents one access per cycle: thread number, address, read/write, byte enables and write data. One cycle later the block answers with exactly one of three results.
- **Hit:** loads return the word.
- **Miss:** the line is being fetched.
- **Retry:** the access was not taken.

A single miss engine serves one miss at a time on a separate memory port that uses a request/grant handshake. While the engine works, other threads keep hitting, because the CPU port and the refill path write the arrays through separate ports. Only the missing thread is held back, by a per-thread pending flag. Each tag entry carries a parity bit, and a mismatch is reported and handled as a miss.

Top module: `pt_dcache`

## Requirements
- R1: After reset, all lines are invalid, no pending flags are set, and no response or memory request is active; the first access to any line misses.
- R2: Each cycle with `cpu_req` high produces exactly one of `rsp_hit`, `rsp_miss`, `rsp_retry` on the next cycle. A cycle without a request produces none of them.
- R3: Address fields are as follows: byte offset `addr[4:0]`, word select `addr[4:2]`, line index `addr[5 +: IDX_W]`, and tag the remaining upper bits. A load hit returns, in `rsp_rdata`, the 32-bit word selected by `addr[4:2]`.
- R4: A store hit writes byte lane `i` (bits `8i+7:8i` of the word) only where `cpu_be[i]` is 1. The other bytes are unchanged, and the line becomes dirty.
- R5: Storage entries are indexed by `{cpu_tid, line_index}`, so lines of different threads with the same line index never evict each other.
- R6: On a miss whose victim is valid and dirty, the engine first writes back the victim (`mem_we`=1, address `{victim_tag, index, 5'b0}`) and only then requests the refill read. A clean or invalid victim causes no write-back.
- R7: A store that misses is completed by the engine. The fetched line is merged with the byte-enabled store data and stored dirty, so the store needs no re-issue.
- R8: After a miss is accepted, every access from that thread gets `rsp_retry` until the refill is written. Hits from other threads are served meanwhile. A load that missed is re-issued by the CPU and then hits.
- R9: A miss from another thread while the engine is busy gets `rsp_retry`, leaves that thread unblocked and starts no memory traffic for it.
- R10: A valid tag entry whose stored parity disagrees with its tag gives `rsp_miss` together with `rsp_parerr`, and the line is refilled.
- R11: `mem_req` stays high with a stable `mem_addr`, `mem_we` and `mem_wdata` until `mem_gnt`. Line addresses have `addr[4:0]`=0, and read data is taken in the grant cycle.
- R12: Lines per thread equal `TOTAL_LINES/THREADS`, must be a power of two and at least 2, and all of them can be resident at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request |
| cpu_tid | input | TID_W | Requesting thread number |
| cpu_addr | input | ADDR_W | Physical byte address |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_be | input | 4 | Store byte enables |
| cpu_wdata | input | 32 | Store data |
| rsp_hit | output | 1 | Access completed as a hit |
| rsp_miss | output | 1 | Miss accepted, refill started |
| rsp_retry | output | 1 | Access not taken, issue again |
| rsp_parerr | output | 1 | Tag parity mismatch seen (with miss) |
| rsp_rdata | output | 32 | Load data on hit |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = line write-back, 0 = line read |
| mem_addr | output | ADDR_W | Line address |
| mem_wdata | output | 256 | Write-back line |
| mem_gnt | input | 1 | Request granted, read data valid |
| mem_rdata | input | 256 | Refill line |

## Verification
The bench builds the cache with 4 threads and 8 lines in total, so each thread owns 2 lines. This small configuration lets every line of every thread be filled, revisited and evicted in a short run. It also lets all 16 byte-enable patterns be swept on a resident word. A six-cycle memory latency keeps the miss engine busy long enough to probe blocking and retries from the stalled thread, from a hitting thread and from a third missing thread. The tags of the thread regions differ, so write-back versus clean eviction, store-miss merging and a parity-corrupted entry can each be traced through the memory port.

// File: rtl/ptdc_pkg.sv
package ptdc_pkg;
   localparam int LINE_BYTES = 32;
   localparam int OFF_W      = $clog2(LINE_BYTES);
   localparam int WORD_W     = 32;
   localparam int LINE_W     = LINE_BYTES * 8;
   localparam int WSEL_W     = $clog2(LINE_BYTES / 4);

   typedef enum logic [1:0] {
      ENG_IDLE = 2'd0,
      ENG_WB   = 2'd1,
      ENG_FILL = 2'd2
   } eng_state_t;
endpackage

// File: rtl/ptdc_tag_array.sv
module ptdc_tag_array #(
   parameter int ENTRIES = 512,
   parameter int IX_W    = 9,
   parameter int TAG_W   = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IX_W-1:0]  rd_ix,
   output logic [TAG_W-1:0] rd_tag,
   output logic             rd_par,
   output logic             rd_valid,
   output logic             rd_dirty,
   input  logic             dirty_set,
   input  logic             fill_we,
   input  logic [IX_W-1:0]  fill_ix,
   input  logic [TAG_W-1:0] fill_tag,
   input  logic             fill_dirty
);
   logic [TAG_W-1:0]   tag_q [ENTRIES];
   logic [ENTRIES-1:0] par_q;
   logic [ENTRIES-1:0] valid_q;
   logic [ENTRIES-1:0] dirty_q;

   assign rd_tag   = tag_q[rd_ix];
   assign rd_par   = par_q[rd_ix];
   assign rd_valid = valid_q[rd_ix];
   assign rd_dirty = dirty_q[rd_ix];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
      end else begin
         if (dirty_set) dirty_q[rd_ix] <= 1'b1;
         if (fill_we) begin
            valid_q[fill_ix] <= 1'b1;
            dirty_q[fill_ix] <= fill_dirty;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (fill_we) begin
         tag_q[fill_ix] <= fill_tag;
         par_q[fill_ix] <= ^fill_tag;
      end
   end
endmodule

// File: rtl/ptdc_data_array.sv
module ptdc_data_array import ptdc_pkg::*; #(
   parameter int ENTRIES = 512,
   parameter int IX_W    = 9
) (
   input  logic              clk,
   input  logic [IX_W-1:0]   c_ix,
   output logic [LINE_W-1:0] c_line,
   input  logic              c_we,
   input  logic [WSEL_W-1:0] c_word,
   input  logic [3:0]        c_be,
   input  logic [WORD_W-1:0] c_wdata,
   input  logic [IX_W-1:0]   e_ix,
   output logic [LINE_W-1:0] e_line,
   input  logic              f_we,
   input  logic [LINE_W-1:0] f_line
);
   logic [LINE_W-1:0] line_q [ENTRIES];

   assign c_line = line_q[c_ix];
   assign e_line = line_q[e_ix];

   always_ff @(posedge clk) begin
      if (f_we) line_q[e_ix] <= f_line;
      if (c_we) begin
         for (int b = 0; b < 4; b++) begin
            if (c_be[b]) line_q[c_ix][int'(c_word) * WORD_W + b * 8 +: 8] <= c_wdata[b * 8 +: 8];
         end
      end
   end
endmodule

// File: rtl/ptdc_miss_engine.sv
module ptdc_miss_engine import ptdc_pkg::*; #(
   parameter int ADDR_W = 32,
   parameter int IX_W   = 9,
   parameter int IDX_W  = 3,
   parameter int TAG_W  = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [IX_W-1:0]   s_ix,
   input  logic [TAG_W-1:0]  s_tag,
   input  logic [TAG_W-1:0]  s_vtag,
   input  logic              s_vdirty,
   input  logic              s_we,
   input  logic [WSEL_W-1:0] s_word,
   input  logic [3:0]        s_be,
   input  logic [WORD_W-1:0] s_wdata,
   output logic              busy,
   output logic              done,
   output logic [IX_W-1:0]   ix,
   output logic [TAG_W-1:0]  fill_tag,
   output logic              fill_dirty,
   output logic [LINE_W-1:0] fill_line,
   input  logic [LINE_W-1:0] vline,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [LINE_W-1:0] mem_wdata,
   input  logic              mem_gnt,
   input  logic [LINE_W-1:0] mem_rdata
);
   eng_state_t        state_q;
   logic [IX_W-1:0]   ix_q;
   logic [TAG_W-1:0]  tag_q, vtag_q;
   logic              we_q;
   logic [WSEL_W-1:0] word_q;
   logic [3:0]        be_q;
   logic [WORD_W-1:0] wdata_q;
   logic [IDX_W-1:0]  idx;

   assign idx        = ix_q[IDX_W-1:0];
   assign busy       = (state_q != ENG_IDLE);
   assign done       = (state_q == ENG_FILL) && mem_gnt;
   assign ix         = ix_q;
   assign fill_tag   = tag_q;
   assign fill_dirty = we_q;
   assign mem_req    = busy;
   assign mem_we     = (state_q == ENG_WB);
   assign mem_addr   = {(state_q == ENG_WB) ? vtag_q : tag_q, idx, {OFF_W{1'b0}}};
   assign mem_wdata  = vline;

   for (genvar g = 0; g < LINE_BYTES; g++) begin : g_merge
      assign fill_line[g*8 +: 8] = (we_q && word_q == WSEL_W'(g / 4) && be_q[g % 4])
                                   ? wdata_q[(g % 4) * 8 +: 8] : mem_rdata[g*8 +: 8];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ENG_IDLE;
      end else begin
         case (state_q)
            ENG_IDLE: if (start) state_q <= s_vdirty ? ENG_WB : ENG_FILL;
            ENG_WB:   if (mem_gnt) state_q <= ENG_FILL;
            ENG_FILL: if (mem_gnt) state_q <= ENG_IDLE;
            default:  state_q <= ENG_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (start && !busy) begin
         ix_q    <= s_ix;
         tag_q   <= s_tag;
         vtag_q  <= s_vtag;
         we_q    <= s_we;
         word_q  <= s_word;
         be_q    <= s_be;
         wdata_q <= s_wdata;
      end
   end
endmodule

// File: rtl/pt_dcache.sv
module pt_dcache import ptdc_pkg::*; #(
   parameter int THREADS     = 64,
   parameter int TOTAL_LINES = 512,
   parameter int ADDR_W      = 32,
   localparam int TID_W      = $clog2(THREADS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic [TID_W-1:0]  cpu_tid,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_we,
   input  logic [3:0]        cpu_be,
   input  logic [31:0]       cpu_wdata,
   output logic              rsp_hit,
   output logic              rsp_miss,
   output logic              rsp_retry,
   output logic              rsp_parerr,
   output logic [31:0]       rsp_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [255:0]      mem_wdata,
   input  logic              mem_gnt,
   input  logic [255:0]      mem_rdata
);
   localparam int LPT   = TOTAL_LINES / THREADS;
   localparam int IDX_W = $clog2(LPT);
   localparam int IX_W  = TID_W + IDX_W;
   localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

   if (THREADS < 2 || (1 << TID_W) != THREADS) begin : g_bad_threads
      $error("THREADS must be a power of two of at least 2");
   end
   if (LPT < 2 || (1 << IDX_W) != LPT || LPT * THREADS != TOTAL_LINES) begin : g_bad_lines
      $error("TOTAL_LINES/THREADS must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W too small for the index and offset");
   end

   logic [IDX_W-1:0]  a_idx;
   logic [TAG_W-1:0]  a_tag;
   logic [WSEL_W-1:0] a_word;
   logic [IX_W-1:0]   a_ix;
   logic [TAG_W-1:0]  t_tag;
   logic              t_par, t_valid, t_dirty;
   logic              par_bad, hit, blocked, go, st_hit, accept;
   logic [LINE_W-1:0] c_line, e_line, fill_line;
   logic [THREADS-1:0] pend_q;
   logic              eng_busy, eng_done, fill_dirty;
   logic [IX_W-1:0]   eng_ix;
   logic [TAG_W-1:0]  fill_tag;
   logic [TID_W-1:0]  eng_tid;

   assign a_idx   = cpu_addr[OFF_W +: IDX_W];
   assign a_tag   = cpu_addr[ADDR_W-1 -: TAG_W];
   assign a_word  = cpu_addr[2 +: WSEL_W];
   assign a_ix    = {cpu_tid, a_idx};
   assign par_bad = t_valid && ((^t_tag) != t_par);
   assign hit     = t_valid && !par_bad && (t_tag == a_tag);
   assign blocked = pend_q[cpu_tid];
   assign go      = cpu_req && !blocked;
   assign st_hit  = go && hit && cpu_we;
   assign accept  = go && !hit && !eng_busy;
   assign eng_tid = eng_ix[IX_W-1 -: TID_W];

   ptdc_tag_array #(.ENTRIES(TOTAL_LINES), .IX_W(IX_W), .TAG_W(TAG_W)) u_tags (
      .clk, .rst_n, .rd_ix(a_ix), .rd_tag(t_tag), .rd_par(t_par), .rd_valid(t_valid),
      .rd_dirty(t_dirty), .dirty_set(st_hit), .fill_we(eng_done), .fill_ix(eng_ix),
      .fill_tag(fill_tag), .fill_dirty(fill_dirty));

   ptdc_data_array #(.ENTRIES(TOTAL_LINES), .IX_W(IX_W)) u_data (
      .clk, .c_ix(a_ix), .c_line(c_line), .c_we(st_hit), .c_word(a_word), .c_be(cpu_be),
      .c_wdata(cpu_wdata), .e_ix(eng_ix), .e_line(e_line), .f_we(eng_done), .f_line(fill_line));

   ptdc_miss_engine #(.ADDR_W(ADDR_W), .IX_W(IX_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_eng (
      .clk, .rst_n, .start(accept), .s_ix(a_ix), .s_tag(a_tag), .s_vtag(t_tag),
      .s_vdirty(t_valid && t_dirty), .s_we(cpu_we), .s_word(a_word), .s_be(cpu_be),
      .s_wdata(cpu_wdata), .busy(eng_busy), .done(eng_done), .ix(eng_ix), .fill_tag(fill_tag),
      .fill_dirty(fill_dirty), .fill_line(fill_line), .vline(e_line), .mem_req, .mem_we,
      .mem_addr, .mem_wdata, .mem_gnt, .mem_rdata);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
      end else begin
         if (accept)   pend_q[cpu_tid] <= 1'b1;
         if (eng_done) pend_q[eng_tid] <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_hit    <= 1'b0;
         rsp_miss   <= 1'b0;
         rsp_retry  <= 1'b0;
         rsp_parerr <= 1'b0;
         rsp_rdata  <= '0;
      end else begin
         rsp_hit    <= go && hit;
         rsp_miss   <= accept;
         rsp_retry  <= cpu_req && (blocked || (!hit && eng_busy));
         rsp_parerr <= accept && par_bad;
         rsp_rdata  <= c_line[int'(a_word) * WORD_W +: WORD_W];
      end
   end
endmodule

// File: rtl/ptdc_checker.sv
module ptdc_checker #(
   parameter int THREADS = 64,
   parameter int ADDR_W  = 32,
   localparam int TID_W  = $clog2(THREADS)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cpu_req,
   input logic [TID_W-1:0]   cpu_tid,
   input logic               rsp_hit,
   input logic               rsp_miss,
   input logic               rsp_retry,
   input logic               rsp_parerr,
   input logic               mem_req,
   input logic               mem_we,
   input logic [ADDR_W-1:0]  mem_addr,
   input logic               mem_gnt,
   input logic [THREADS-1:0] pend_q
);
   AST_RSP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rsp_hit, rsp_miss, rsp_retry})); // R2
   AST_RSP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_req |=> !(rsp_hit || rsp_miss || rsp_retry)); // R2
   AST_PEND_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && pend_q[cpu_tid] |=> rsp_retry); // R8
   AST_SINGLE_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(pend_q) <= 1); // R9
   AST_PARERR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_parerr |-> rsp_miss); // R10
   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R11
   AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_addr[4:0] == 5'd0); // R11
   AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && mem_gnt |=> mem_req && !mem_we); // R6
endmodule

bind pt_dcache ptdc_checker #(.THREADS(THREADS), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_pt_dcache.sv
`timescale 1ns/1ps
module test_pt_dcache;
   localparam int TH = 4, TL = 8, AW = 32, LAT = 6, TW = 2;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n, cpu_req, cpu_we, rsp_hit, rsp_miss, rsp_retry, rsp_parerr;
   logic mem_req, mem_we, mem_gnt;
   logic [TW-1:0] cpu_tid;
   logic [AW-1:0] cpu_addr, mem_addr;
   logic [3:0] cpu_be;
   logic [31:0] cpu_wdata, rsp_rdata;
   logic [255:0] mem_wdata, mem_rdata;

   pt_dcache #(.THREADS(TH), .TOTAL_LINES(TL), .ADDR_W(AW)) i_pt_dcache (.*);

   int nchk = 0, nerr = 0, wb_cnt = 0, hold_err = 0;
   logic last_we = 0, prev_we = 0;
   logic [31:0] last_addr = 0, prev_addr = 0;
   logic [255:0] mline [int unsigned];
   logic [31:0] shw [int unsigned];

   function automatic logic [31:0] pat(input logic [31:0] a);
      return {a[15:0] ^ 16'hC3A5, ~a[15:0]};
   endfunction
   function automatic logic [31:0] exp_w(input logic [31:0] a);
      return shw.exists(a) ? shw[a] : pat(a);
   endfunction
   function automatic logic [255:0] line_of(input logic [31:0] la);
      logic [255:0] l;
      if (mline.exists(la)) return mline[la];
      for (int w = 0; w < 8; w++) l[w*32 +: 32] = pat(la + 32'(w * 4));
      return l;
   endfunction
   function automatic logic [31:0] base(input int t);
      return 32'(t) << 16;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic upd(input logic [31:0] a, input logic [3:0] be, input logic [31:0] wd);
      logic [31:0] v = exp_w(a);
      for (int b = 0; b < 4; b++) if (be[b]) v[b*8 +: 8] = wd[b*8 +: 8];
      shw[a] = v;
   endtask

   // memory model: grants after LAT waiting negedges, data valid with grant
   initial begin
      int cnt = 0;
      mem_gnt = 0;
      mem_rdata = '0;
      forever begin
         @(negedge clk);
         if (mem_gnt) mem_gnt = 0;
         else if (mem_req) begin
            if (cnt >= LAT) begin
               cnt = 0;
               mem_gnt = 1;
               prev_we = last_we; prev_addr = last_addr;
               last_we = mem_we; last_addr = mem_addr;
               if (mem_we) begin mline[mem_addr] = mem_wdata; wb_cnt++; end
               else mem_rdata = line_of(mem_addr);
            end else cnt++;
         end else if (cnt != 0) begin
            hold_err++;
            cnt = 0;
         end
      end
   end

   task automatic issue1(input int t, input logic [31:0] a, input logic we,
                         input logic [3:0] be, input logic [31:0] wd);
      @(negedge clk);
      cpu_req = 1; cpu_tid = TW'(t); cpu_addr = a; cpu_we = we; cpu_be = be; cpu_wdata = wd;
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      @(negedge clk);
      cpu_req = 0; cpu_we = 0;
   endtask

   task automatic acc(input int t, input logic [31:0] a, input logic we, input logic [3:0] be,
                      input logic [31:0] wd, output int nm, output logic [31:0] rd, output bit pe);
      logic cw = we;
      nm = 0; pe = 0; rd = 'x;
      for (int k = 0; k < 200; k++) begin
         issue1(t, a, cw, be, wd);
         if (rsp_hit) begin rd = rsp_rdata; break; end
         if (rsp_miss) begin nm++; pe = pe | rsp_parerr; cw = 0; end
      end
      idle();
   endtask

   initial begin
      int nm, w0;
      bit pe;
      logic [31:0] rd, a, a2;
      logic [TL-1:0] snap;
      cpu_req = 0; cpu_we = 0; cpu_tid = 0; cpu_addr = 0; cpu_be = 0; cpu_wdata = 0;
      rst_n = 0;
      repeat (3) @(posedge clk);
      #1;
      chk(!rsp_hit && !rsp_miss && !rsp_retry && !mem_req, "R1", "outputs idle in reset",
          {28'd0, rsp_hit, rsp_miss, rsp_retry, mem_req}, 32'd0);
      @(negedge clk); rst_n = 1;

      // R1 R3 R5 R12: every line of every thread misses once, then all stay resident
      for (int t = 0; t < TH; t++)
         for (int i = 0; i < 2; i++) begin
            a = base(t) + 32'(i * 32) + 32'(4 * ((t + i) % 8));
            acc(t, a, 0, 4'h0, 0, nm, rd, pe);
            chk(nm == 1, "R1", "cold access miss count", 32'(nm), 32'd1);
            chk(rd == exp_w(a), "R3", "refilled word", rd, exp_w(a));
         end
      for (int t = 0; t < TH; t++)
         for (int i = 0; i < 2; i++)
            for (int w = 0; w < 8; w++) begin
               a = base(t) + 32'(i * 32 + w * 4);
               acc(t, a, 0, 4'h0, 0, nm, rd, pe);
               chk(nm == 0, "R5", "resident across threads", 32'(nm), 32'd0);
               chk(nm == 0, "R12", "all lines per thread resident", 32'(nm), 32'd0);
               chk(rd == exp_w(a), "R3", "word select", rd, exp_w(a));
            end

      // R2: no request gives no response
      @(posedge clk); #1;
      chk(!rsp_hit && !rsp_miss && !rsp_retry, "R2", "no response without request",
          {29'd0, rsp_hit, rsp_miss, rsp_retry}, 32'd0);

      // R4: all byte-enable patterns on a resident word
      for (int be = 0; be < 16; be++) begin
         a = base(0) + 32'd4;
         acc(0, a, 1, 4'(be), 32'hA0B0C0D0 ^ (32'(be) * 32'h01010101), nm, rd, pe);
         chk(nm == 0, "R4", "store hit", 32'(nm), 32'd0);
         upd(a, 4'(be), 32'hA0B0C0D0 ^ (32'(be) * 32'h01010101));
         acc(0, a, 0, 4'h0, 0, nm, rd, pe);
         chk(rd == exp_w(a), "R4", "byte merge", rd, exp_w(a));
         acc(0, base(0) + 32'd8, 0, 4'h0, 0, nm, rd, pe);
         chk(rd == exp_w(base(0) + 32'd8), "R4", "neighbour word intact", rd, exp_w(base(0) + 32'd8));
      end

      // R6: dirty victim written back before refill read
      w0 = wb_cnt;
      a2 = base(0) + 32'h1000;
      acc(0, a2, 0, 4'h0, 0, nm, rd, pe);
      chk(nm == 1, "R6", "conflict miss", 32'(nm), 32'd1);
      chk(wb_cnt == w0 + 1, "R6", "write-back count", 32'(wb_cnt), 32'(w0 + 1));
      chk(prev_we && prev_addr == base(0), "R6", "write-back first, victim address", prev_addr, base(0));
      chk(!last_we && last_addr == a2, "R6", "refill after write-back", last_addr, a2);
      chk(line_of(base(0))[63:32] == exp_w(base(0) + 32'd4), "R6", "written-back data",
          line_of(base(0))[63:32], exp_w(base(0) + 32'd4));
      w0 = wb_cnt;
      acc(0, base(0) + 32'd4, 0, 4'h0, 0, nm, rd, pe);
      chk(wb_cnt == w0, "R6", "clean victim not written back", 32'(wb_cnt), 32'(w0));
      chk(rd == exp_w(base(0) + 32'd4), "R6", "data back from memory", rd, exp_w(base(0) + 32'd4));

      // R7: store miss allocates, merges, marks dirty
      a = base(1) + 32'h2008;
      upd(a, 4'b0110, 32'h11223344);
      acc(1, a, 1, 4'b0110, 32'h11223344, nm, rd, pe);
      chk(nm == 1, "R7", "store miss count", 32'(nm), 32'd1);
      chk(rd == exp_w(a), "R7", "merged word", rd, exp_w(a));
      w0 = wb_cnt;
      acc(1, base(1) + 32'd8, 0, 4'h0, 0, nm, rd, pe);
      chk(wb_cnt == w0 + 1, "R7", "store-miss line dirty", 32'(wb_cnt), 32'(w0 + 1));
      chk(line_of(base(1) + 32'h2000)[95:64] == exp_w(a), "R7", "merged line in memory",
          line_of(base(1) + 32'h2000)[95:64], exp_w(a));

      // R8 R9: blocking of the missing thread only
      a = base(0) + 32'h3000;
      issue1(0, a, 0, 4'h0, 0);
      chk(rsp_miss, "R8", "miss accepted", 32'(rsp_miss), 32'd1);
      issue1(0, a, 0, 4'h0, 0);
      chk(rsp_retry, "R8", "same thread retried", 32'(rsp_retry), 32'd1);
      issue1(1, base(1) + 32'd36, 0, 4'h0, 0);
      chk(rsp_hit, "R8", "other thread hits", 32'(rsp_hit), 32'd1);
      chk(rsp_rdata == exp_w(base(1) + 32'd36), "R8", "other thread data", rsp_rdata, exp_w(base(1) + 32'd36));
      issue1(2, base(2) + 32'h3000, 0, 4'h0, 0);
      chk(rsp_retry, "R9", "second miss retried while busy", 32'(rsp_retry), 32'd1);
      chk($countones({rsp_hit, rsp_miss, rsp_retry}) == 1, "R2", "single response",
          {29'd0, rsp_hit, rsp_miss, rsp_retry}, 32'd1);
      idle();
      acc(0, a, 0, 4'h0, 0, nm, rd, pe);
      chk(nm == 0, "R8", "re-issue after refill without new miss", 32'(nm), 32'd0);
      chk(rd == exp_w(a), "R8", "re-issued load data", rd, exp_w(a));
      issue1(2, base(2) + 32'h3000, 0, 4'h0, 0);
      chk(rsp_miss, "R9", "retried thread was not blocked", 32'(rsp_miss), 32'd1);
      idle();
      acc(2, base(2) + 32'h3000, 0, 4'h0, 0, nm, rd, pe);
      chk(rd == exp_w(base(2) + 32'h3000), "R9", "later refill data", rd, exp_w(base(2) + 32'h3000));

      // R10: corrupt the parity of entry {tid 3, index 1} = 7
      @(negedge clk);
      snap = i_pt_dcache.u_tags.par_q;
      snap[7] = ~snap[7];
      force i_pt_dcache.u_tags.par_q = snap;
      a = base(3) + 32'd44;
      issue1(3, a, 0, 4'h0, 0);
      chk(rsp_miss && rsp_parerr, "R10", "parity mismatch reported as miss",
          {30'd0, rsp_miss, rsp_parerr}, 32'd3);
      idle();
      release i_pt_dcache.u_tags.par_q;
      acc(3, a, 0, 4'h0, 0, nm, rd, pe);
      chk(rd == exp_w(a), "R10", "refilled after parity error", rd, exp_w(a));
      acc(3, a, 0, 4'h0, 0, nm, rd, pe);
      chk(nm == 0 && !pe, "R10", "clean hit after refill", 32'(nm), 32'd0);

      chk(hold_err == 0, "R11", "request held until grant", 32'(hold_err), 32'd0);

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      nchk++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule